// File: doc/BRIEF.md
# Lookup-Table Butterfly Permutation Unit

This block is a 64-bit bit-permutation and pattern unit built on the butterfly network used by generalized reverse. It has six stages, and each stage can be enabled on its own. An enabled stage does not apply a fixed swap. Instead, every output bit is computed by a two-input lookup table over the pair of bits that the stage would exchange. The lower and upper member of each pair have separate 4-bit tables, taken from the two nibbles of an 8-bit immediate.

With suitable immediates the unit performs a plain generalized reverse or a generalized OR-combine. When no operand register is supplied, it starts from an alternating constant, which can be inverted. This lets it build regular repeating mask constants in a single operation.

A thin registered wrapper captures the combinational result when a valid strobe is presented. The result appears one cycle later, together with a valid output.

Top module: `grevlut_top`

## Requirements
- R1: While `rstN` is low, `validOut` and `result` are held at zero.
- R2: A word presented with `validIn` high appears on `result` with `validOut` high after exactly one rising clock edge. With `validIn` low, `validOut` falls and `result` keeps its previous value, whatever the other inputs do.
- R3: Stage k (k = 0..5) works on bit pairs at distance 2^k and is applied only when `amount[k]` is 1. Enabled stages run from distance 1 upward. With `amount[5:0]` zero, the starting value passes through unchanged.
- R4: In an enabled stage, take a pair with lower position p and upper position p+d. Let idx = 2*bit[p] + bit[p+d]. The new bit at p is `imm[idx]` and the new bit at p+d is `imm[4+idx]`.
- R5: When `operandAbsent` is 1, the starting value is 0x5555555555555555 and `operand` is ignored.
- R6: When `invert` is 1, the starting value is inverted bitwise. With `operandAbsent` also set, this gives 0xAAAAAAAAAAAAAAAA.
- R7: `imm` = 0xCA produces the generalized reverse of the starting value for the given amount.
- R8: `imm` = 0xEE produces the generalized OR-combine of the starting value for the given amount.
- R9: With the alternating seed, the following mask constants are produced. Amount 0b10/0b110/0b1110 with imm 0x6C and no inversion gives 0x1111.., 0x0101.. and 0x00010001... Amount 0b10/0b110/0b1110 with imm 0xC6 and inversion gives 0x8888.., 0x8080.. and 0x80008000...
- R10: Bits of `amount` above bit 5 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| validIn | input | 1 | Capture strobe for the current inputs |
| operand | input | 64 | Data operand |
| operandAbsent | input | 1 | 1 selects the alternating seed instead of `operand` |
| amount | input | 64 | Stage-select amount; only bits 5:0 are used |
| imm | input | 8 | Lookup tables: [3:0] lower positions, [7:4] upper positions |
| invert | input | 1 | Invert the starting value |
| validOut | output | 1 | Result valid, one cycle after `validIn` |
| result | output | 64 | Registered result |

## Verification
The bench uses the default width of 64 bits, which gives six stages. All 64 amount codes and the full 8-bit immediate space can therefore be reached by random stimulus. Separate reference functions for plain reverse and OR-combine check the 0xCA and 0xEE immediates without going through the table model. The six stated mask constants are checked as directed cases. Random upper bits in `amount`, and operands that are present but not selected, show at the result port that those inputs have no effect.

// File: rtl/grevlut_pkg.sv
package grevlut_pkg;
  // Strobes the control stage hands to the datapath.
  typedef struct packed {
    logic       useSeed;
    logic       invert;
    logic [3:0] lutLo;
    logic [3:0] lutHi;
  } lutCtrlT;
endpackage

// File: rtl/grevlut_ctrl.sv
module grevlut_ctrl
  import grevlut_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int STAGES = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] amount,
  input  logic              operandAbsent,
  input  logic              invert,
  input  logic [7:0]        imm,
  output lutCtrlT           ctrl,
  output logic [STAGES-1:0] stageEn
);
  // Only the low stage-select bits matter (R10).
  logic unusedAmtHigh;
  assign unusedAmtHigh = ^amount[DATA_W-1:STAGES];

  assign stageEn      = amount[STAGES-1:0];
  assign ctrl.useSeed = operandAbsent;
  assign ctrl.invert  = invert;
  assign ctrl.lutLo   = imm[3:0];
  assign ctrl.lutHi   = imm[7:4];
endmodule

// File: rtl/grevlut_dp.sv
module grevlut_dp
  import grevlut_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int STAGES = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  lutCtrlT           ctrl,
  input  logic [STAGES-1:0] stageEn,
  output logic [DATA_W-1:0] outWord
);
  localparam logic [DATA_W-1:0] SEED_WORD = {(DATA_W/2){2'b01}};

  logic [STAGES:0][DATA_W-1:0] stageVal;

  // Starting value: seed or operand, optionally inverted (R5, R6).
  assign stageVal[0] = (ctrl.useSeed ? SEED_WORD : operand) ^ {DATA_W{ctrl.invert}};

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    localparam int DIST = 1 << s;
    for (genvar j = 0; j < DATA_W; j++) begin : gBit
      localparam int PART = j ^ DIST;
      if ((j & DIST) != 0) begin : gUpper
        // Upper member: index is {lower bit, own bit} into high nibble (R4).
        assign stageVal[s+1][j] = stageEn[s]
          ? ctrl.lutHi[{stageVal[s][PART], stageVal[s][j]}]
          : stageVal[s][j];
      end else begin : gLower
        // Lower member: index is {own bit, upper bit} into low nibble (R4).
        assign stageVal[s+1][j] = stageEn[s]
          ? ctrl.lutLo[{stageVal[s][j], stageVal[s][PART]}]
          : stageVal[s][j];
      end
    end
  end

  assign outWord = stageVal[STAGES];
endmodule

// File: rtl/grevlut_top.sv
module grevlut_top
  import grevlut_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int STAGES = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              operandAbsent,
  input  logic [DATA_W-1:0] amount,
  input  logic [7:0]        imm,
  input  logic              invert,
  output logic              validOut,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] SEED_WORD = {(DATA_W/2){2'b01}};

  lutCtrlT           ctrl;
  logic [STAGES-1:0] stageEn;
  logic [DATA_W-1:0] dpOut;

  grevlut_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .amount(amount), .operandAbsent(operandAbsent), .invert(invert),
    .imm(imm), .ctrl(ctrl), .stageEn(stageEn)
  );

  grevlut_dp #(.DATA_W(DATA_W)) i_dp (
    .operand(operand), .ctrl(ctrl), .stageEn(stageEn), .outWord(dpOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut <= 1'b0;
      result   <= '0;
    end else begin
      validOut <= validIn;
      if (validIn) result <= dpOut;
    end
  end

  // R2: one-cycle latency and hold when idle
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!validOut && $stable(result)));
  // R3: no stage enabled passes the operand through
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && amount[STAGES-1:0] == '0 && !operandAbsent && !invert)
      |=> result == $past(operand));
  // R5: seed start value
  assert_seed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && amount[STAGES-1:0] == '0 && operandAbsent && !invert)
      |=> result == SEED_WORD);
  // R7: the reverse table only permutes, so the ones count is kept
  assert_grev_popcount_R7: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && imm == 8'hCA && !operandAbsent && !invert)
      |=> $countones(result) == $countones($past(operand)));
  // R8: the OR-combine table never clears a bit that was set
  assert_gorc_cover_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && imm == 8'hEE && !operandAbsent && !invert)
      |=> (result & $past(operand)) == $past(operand));
endmodule

// File: tb/test_grevlut_top.sv
`timescale 1ns/1ps
module test_grevlut_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [63:0] operand = '0;
  logic        operandAbsent = 1'b0;
  logic [63:0] amount = '0;
  logic [7:0]  imm = '0;
  logic        invert = 1'b0;
  logic        validOut;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  grevlut_top i_grevlut_top (
    .clk(clk), .rstN(rstN), .validIn(validIn), .operand(operand),
    .operandAbsent(operandAbsent), .amount(amount), .imm(imm),
    .invert(invert), .validOut(validOut), .result(result)
  );

  function automatic logic [63:0] grevRef(logic [63:0] x, logic [5:0] k);
    logic [63:0] y;
    for (int s = 0; s < 6; s++) begin
      if (k[s]) begin
        for (int j = 0; j < 64; j++) y[j] = x[j ^ (1 << s)];
        x = y;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] gorcRef(logic [63:0] x, logic [5:0] k);
    logic [63:0] y;
    for (int s = 0; s < 6; s++) begin
      if (k[s]) begin
        for (int j = 0; j < 64; j++) y[j] = x[j] | x[j ^ (1 << s)];
        x = y;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] startVal(logic [63:0] op, logic absent, logic inv);
    logic [63:0] v;
    v = absent ? 64'h5555_5555_5555_5555 : op;
    return inv ? ~v : v;
  endfunction

  function automatic logic [63:0] lutModel(logic [63:0] x, logic [5:0] k, logic [7:0] t);
    logic [63:0] y;
    int d, lo, hi, idx;
    for (int s = 0; s < 6; s++) begin
      if (k[s]) begin
        d = 1 << s;
        for (int p = 0; p < 64; p++) begin
          if ((p & d) == 0) begin
            lo = p; hi = p + d;
            idx = 2 * int'(x[lo]) + int'(x[hi]);
            y[lo] = t[idx];
            y[hi] = t[4 + idx];
          end
        end
        x = y;
      end
    end
    return x;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] op, input logic absent, input logic [63:0] amt,
                       input logic [7:0] t, input logic inv);
    @(negedge clk);
    operand = op; operandAbsent = absent; amount = amt; imm = t; invert = inv;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] op, amt, exp, held;
    logic [7:0]  t;
    logic        ab, inv;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 validOut", {63'b0, validOut}, 64'd0);
    check("R1 result", result, 64'd0);
    rstN = 1'b1;

    // R9: directed mask constants
    runOp(64'h0, 1'b1, 64'b10, 8'b01101100, 1'b0);
    check("R9 a", result, 64'h1111_1111_1111_1111);
    runOp(64'h0, 1'b1, 64'b110, 8'b01101100, 1'b0);
    check("R9 b", result, 64'h0101_0101_0101_0101);
    runOp(64'h0, 1'b1, 64'b1110, 8'b01101100, 1'b0);
    check("R9 c", result, 64'h0001_0001_0001_0001);
    runOp(64'h0, 1'b1, 64'b10, 8'b11000110, 1'b1);
    check("R9 d", result, 64'h8888_8888_8888_8888);
    runOp(64'h0, 1'b1, 64'b110, 8'b11000110, 1'b1);
    check("R9 e", result, 64'h8080_8080_8080_8080);
    runOp(64'h0, 1'b1, 64'b1110, 8'b11000110, 1'b1);
    check("R9 f", result, 64'h8000_8000_8000_8000);

    // R5 / R6: seeds with no stage, operand ignored
    runOp(64'hDEAD_BEEF_0123_4567, 1'b1, 64'h0, 8'h00, 1'b0);
    check("R5 seed", result, 64'h5555_5555_5555_5555);
    runOp(64'hDEAD_BEEF_0123_4567, 1'b1, 64'h0, 8'hFF, 1'b1);
    check("R6 inverted seed", result, 64'hAAAA_AAAA_AAAA_AAAA);
    runOp(64'h0F0F_0000_FFFF_1234, 1'b0, 64'h0, 8'h5A, 1'b1);
    check("R6 inverted operand", result, ~64'h0F0F_0000_FFFF_1234);

    // R3: bypass and full reverse
    runOp(64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 8'h3C, 1'b0);
    check("R3 bypass", result, 64'h0123_4567_89AB_CDEF);
    runOp(64'h0000_0000_0000_0001, 1'b0, 64'd63, 8'hCA, 1'b0);
    check("R3 full reverse", result, 64'h8000_0000_0000_0000);

    // R2: latency and hold
    runOp(64'h1357_9BDF_0246_8ACE, 1'b0, 64'd5, 8'hCA, 1'b0);
    check("R2 validOut high", {63'b0, validOut}, 64'd1);
    held = result;
    operand = 64'hFFFF_0000_FFFF_0000; amount = 64'd7; imm = 8'h11;
    @(negedge clk);
    check("R2 validOut low", {63'b0, validOut}, 64'd0);
    check("R2 hold", result, held);

    // R4: table semantics against model, random
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 300; n++) begin
      op = {$urandom(), $urandom()}; amt = {$urandom(), $urandom()};
      t = 8'($urandom()); ab = 1'($urandom()); inv = 1'($urandom());
      runOp(op, ab, amt, t, inv);
      exp = lutModel(startVal(op, ab, inv), amt[5:0], t);
      check("R4 random", result, exp);
    end

    // R7 / R8: reverse and OR-combine immediates
    for (int n = 0; n < 150; n++) begin
      op = {$urandom(), $urandom()}; amt = 64'($urandom_range(0, 63));
      inv = 1'($urandom());
      runOp(op, 1'b0, amt, 8'hCA, inv);
      check("R7 grev", result, grevRef(startVal(op, 1'b0, inv), amt[5:0]));
      runOp(op, 1'b0, amt, 8'hEE, inv);
      check("R8 gorc", result, gorcRef(startVal(op, 1'b0, inv), amt[5:0]));
    end

    // R10: upper amount bits have no effect
    for (int n = 0; n < 100; n++) begin
      op = {$urandom(), $urandom()}; t = 8'($urandom());
      amt = {$urandom(), $urandom()};
      runOp(op, 1'b0, amt | 64'hFFFF_FFFF_FFFF_FFC0, t, 1'b0);
      check("R10 upper bits", result, lutModel(op, amt[5:0], t));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule